// File: doc/BRIEF.md
# Dual Reference Monitor with Automatic Switchover

This block watches two reference clocks using a fast system clock and picks the one that feeds the phase-locked loop. Each reference goes through a synchronizer. The block then measures the number of system-clock cycles between its rising edges and compares that count with a programmed expected period and tolerance. A reference is declared unusable if its edges stop arriving or if its period stays outside the tolerance. A reference that has failed is accepted again only after a run of good periods.

A small selector uses the two health flags to choose what drives the loop. The primary reference is used first. If the active reference fails and the other one is healthy, the selector moves to the other one. If both have failed, it asks the loop for holdover. Each time the selection or the holdover state changes, the block emits a one-cycle strobe. The loop uses this strobe to clear its phase-detector state, so that the change of reference does not reach the loop as a phase step.

Top module: `ref_guard`

## Requirements
- R1: During and right after reset, both health flags are 0, `holdover` is 1, `use_sec` is 0 and `switch_pulse` is 0.
- R2: Loss check. Let E be the programmed expected period. If no further rising edge arrives after a reference's last one, its health flag drops on the clock edge 2*E+2 cycles after the first system clock edge that samples that last high level.
- R3: The period is measured in system cycles between synchronized rising edges. Four consecutive measured periods with |period - E| greater than the tolerance clear the health flag. Three such periods followed by one in-tolerance period leave the flag set.
- R4: A measured period whose difference from E equals the tolerance counts as in tolerance.
- R5: An unhealthy reference becomes healthy again after one priming rising edge followed by 8 consecutive in-tolerance periods. The flag changes 3 cycles after the edge that causes it; a drift drop (R3) has the same delay.
- R6: If the selected reference becomes unhealthy and the other one is healthy, the selection moves to the other one on the next cycle. `use_sec` = 1 means the secondary is selected.
- R7: If the selected reference fails and the other is also unhealthy, `holdover` goes to 1 and `use_sec` goes to 0. Holdover is left as soon as either reference is healthy. The primary wins if both become healthy in the same cycle.
- R8: While on the secondary with both references healthy, the selector returns to the primary when `revertive` is 1 and stays on the secondary when it is 0.
- R9: `switch_pulse` is high for exactly the cycles in which `use_sec` or `holdover` changes, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prim_ref | input | 1 | Primary reference clock, asynchronous |
| sec_ref | input | 1 | Secondary reference clock, asynchronous |
| prim_period | input | PER_W | Expected primary period, in system cycles |
| sec_period | input | PER_W | Expected secondary period, in system cycles |
| prim_tol | input | PER_W | Allowed primary period deviation, in cycles |
| sec_tol | input | PER_W | Allowed secondary period deviation, in cycles |
| revertive | input | 1 | 1: return to the primary when it recovers |
| prim_ok | output | 1 | Primary reference healthy |
| sec_ok | output | 1 | Secondary reference healthy |
| use_sec | output | 1 | Secondary selected (0 during holdover) |
| holdover | output | 1 | Neither reference selected, loop should hold |
| switch_pulse | output | 1 | One-cycle strobe on every selection change |

## Verification
A health flag changes 3 cycles after the reference edge that decides it: two synchronizer stages and one qualification register. A loss is flagged 2*E+3 cycles after the negative edge on which the bench raised that last reference level. The bench records the cycle of every rising edge it drives and checks each expected health change against that cycle plus the offset. Selection and holdover changes come one cycle after the health change that causes them. The strobe is compared with those changes in the same cycle, and every output transition must match the next entry in the queue of expected events.

// File: rtl/refguard_pkg.sv
`timescale 1ns/1ps
// Shared types for the reference monitor: selector state encoding.
package refguard_pkg;
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_PRIM = 2'd1,
        SRC_SEC  = 2'd2
    } src_e;
endpackage

// File: rtl/refguard_edge.sv
`timescale 1ns/1ps
// refguard_edge: brings an asynchronous reference into the system clock
// domain through STAGES flops, then flags each rising edge for one cycle.
// Assumes the reference stays high and low for at least two system cycles.
module refguard_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/refguard_chan.sv
`timescale 1ns/1ps
// refguard_chan: health qualifier for one reference. It counts system
// cycles between synchronized rising edges. It flags loss when no edge
// arrives within twice the expected period, and drift after DRIFT_RUN
// consecutive out-of-tolerance periods. It requalifies after a priming
// edge plus RECOVER_RUN good periods.
// Assumes exp_period is nonzero and below half the counter range.
module refguard_chan #(
    parameter int PER_W       = 16,
    parameter int STAGES      = 2,
    parameter int DRIFT_RUN   = 4,
    parameter int RECOVER_RUN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_async,
    input  logic [PER_W-1:0] exp_period,
    input  logic [PER_W-1:0] tol,
    output logic             ok
);
    localparam int CNT_W  = PER_W + 1;
    localparam int BAD_W  = $clog2(DRIFT_RUN + 1);
    localparam int GOOD_W = $clog2(RECOVER_RUN + 1);
    localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(DRIFT_RUN - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RECOVER_RUN - 1);
    localparam logic [GOOD_W-1:0] GOOD_SAT  = GOOD_W'(RECOVER_RUN);

    logic              rise;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  expw;
    logic [CNT_W-1:0]  diff;
    logic              in_tol;
    logic              lost;
    logic              primed;
    logic [BAD_W-1:0]  bad;
    logic [GOOD_W-1:0] good;

    refguard_edge #(.STAGES(STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_async),
        .rise     (rise)
    );

    assign expw   = {1'b0, exp_period};
    assign lim    = {exp_period, 1'b0};
    assign diff   = (cnt >= expw) ? (cnt - expw) : (expw - cnt);
    assign in_tol = (diff <= {1'b0, tol});
    assign lost   = !rise && (cnt >= lim);

    // Period counter: restarts at 1 on each edge, saturates at the loss limit.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (rise)       cnt <= CNT_W'(1);
        else if (cnt < lim)  cnt <= cnt + 1'b1;
    end

    // Health state: loss clears everything, edges update the run counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok     <= 1'b0;
            primed <= 1'b0;
            bad    <= '0;
            good   <= '0;
        end else if (lost) begin
            ok     <= 1'b0;
            primed <= 1'b0;
            bad    <= '0;
            good   <= '0;
        end else if (rise) begin
            primed <= 1'b1;
            if (primed) begin
                if (in_tol) begin
                    bad <= '0;
                    if (good != GOOD_SAT) good <= good + 1'b1;
                    if (good == GOOD_LAST) ok <= 1'b1;
                end else begin
                    good <= '0;
                    if (bad == BAD_LAST) begin
                        ok  <= 1'b0;
                        bad <= '0;
                    end else begin
                        bad <= bad + 1'b1;
                    end
                end
            end
        end
    end

    // A flag only drops after a loss or after the last of a run of bad periods.
    assert_drop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok) |-> ($past(lost) ||
                       ($past(rise) && $past(bad) == BAD_LAST && !$past(in_tol))));

    // A flag only rises after the run of good periods is complete.
    assert_requalify_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> ($past(good) == GOOD_LAST && $past(primed)));

    // R2: the gap counter never runs past twice the expected period.
    assert_gap_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(exp_period) |-> cnt <= lim);
endmodule

// File: rtl/refguard_sel.sv
`timescale 1ns/1ps
// refguard_sel: chooses the reference that drives the loop from the two
// health flags. Order of preference: primary, secondary, holdover. The
// selector optionally reverts to the primary, and strobes for one cycle
// each time its state changes.
// Assumes the health flags are synchronous to clk.
module refguard_sel
    import refguard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prim_ok,
    input  logic sec_ok,
    input  logic revertive,
    output src_e src,
    output logic pulse
);
    src_e nxt;

    // Next-source decision from the current source and the health flags.
    always_comb begin
        nxt = src;
        case (src)
            SRC_PRIM: if (!prim_ok) nxt = sec_ok ? SRC_SEC : SRC_HOLD;
            SRC_SEC: begin
                if (!sec_ok)                    nxt = prim_ok ? SRC_PRIM : SRC_HOLD;
                else if (revertive && prim_ok)  nxt = SRC_PRIM;
            end
            default: begin
                if (prim_ok)     nxt = SRC_PRIM;
                else if (sec_ok) nxt = SRC_SEC;
            end
        endcase
    end

    // Source register and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= SRC_HOLD;
            pulse <= 1'b0;
        end else begin
            src   <= nxt;
            pulse <= (nxt != src);
        end
    end

    assert_failover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_PRIM && !prim_ok && sec_ok) |=> src == SRC_SEC);

    assert_hold_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_HOLD) ##1 (src == SRC_HOLD) |-> $past(!prim_ok && !sec_ok));

    assert_revert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SEC && sec_ok && prim_ok && revertive) |=> src == SRC_PRIM);

    assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src != $past(src)) |-> pulse);
endmodule

// File: rtl/ref_guard.sv
`timescale 1ns/1ps
// ref_guard: top of the dual reference monitor. One qualifier channel
// runs per reference and feeds a selector. The outputs are the health
// flags, the selection, the holdover request and the switch strobe.
// Assumes clk is much faster than either reference.
module ref_guard
    import refguard_pkg::*;
#(
    parameter int PER_W       = 16,
    parameter int STAGES      = 2,
    parameter int DRIFT_RUN   = 4,
    parameter int RECOVER_RUN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prim_ref,
    input  logic             sec_ref,
    input  logic [PER_W-1:0] prim_period,
    input  logic [PER_W-1:0] sec_period,
    input  logic [PER_W-1:0] prim_tol,
    input  logic [PER_W-1:0] sec_tol,
    input  logic             revertive,
    output logic             prim_ok,
    output logic             sec_ok,
    output logic             use_sec,
    output logic             holdover,
    output logic             switch_pulse
);
    localparam int NREF = 2;

    logic [NREF-1:0]  raw;
    logic [NREF-1:0]  okv;
    logic [PER_W-1:0] per_a [NREF];
    logic [PER_W-1:0] tol_a [NREF];
    src_e             src;

    assign raw      = {sec_ref, prim_ref};
    assign per_a[0] = prim_period;
    assign per_a[1] = sec_period;
    assign tol_a[0] = prim_tol;
    assign tol_a[1] = sec_tol;

    for (genvar g = 0; g < NREF; g++) begin : g_chan
        refguard_chan #(
            .PER_W       (PER_W),
            .STAGES      (STAGES),
            .DRIFT_RUN   (DRIFT_RUN),
            .RECOVER_RUN (RECOVER_RUN)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_async  (raw[g]),
            .exp_period (per_a[g]),
            .tol        (tol_a[g]),
            .ok         (okv[g])
        );
    end

    refguard_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .prim_ok   (okv[0]),
        .sec_ok    (okv[1]),
        .revertive (revertive),
        .src       (src),
        .pulse     (switch_pulse)
    );

    assign prim_ok  = okv[0];
    assign sec_ok   = okv[1];
    assign use_sec  = (src == SRC_SEC);
    assign holdover = (src == SRC_HOLD);

    assert_hold_clears_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |-> !use_sec);
endmodule

// File: tb/ref_guard_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output events and the
// monitor pops and compares them as outputs change.
module ref_guard_bench;
    localparam int PW = 16;
    localparam int E  = 20;

    typedef struct {
        int    kind;   // 0 prim_ok, 1 sec_ok, 2 use_sec, 3 holdover
        bit    val;
        int    off;    // cycles after last driven rise, -1 = untimed
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ref_drv = 2'b00;
    logic [PW-1:0] p0 = PW'(E), p1 = PW'(E), t0 = PW'(2), t1 = PW'(2);
    logic revertive = 1'b0;
    logic prim_ok, sec_ok, use_sec, holdover, switch_pulse;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit run_on = 1'b0;
    bit done = 1'b0;
    int per[2];
    bit en[2];
    int ph[2];
    int cur_p[2];
    int edges[2];
    int last_rise[2];
    item_t sbq[$];
    logic [3:0] prev;

    ref_guard u_ref_guard (
        .clk(clk), .rst_n(rst_n), .prim_ref(ref_drv[0]), .sec_ref(ref_drv[1]),
        .prim_period(p0), .sec_period(p1), .prim_tol(t0), .sec_tol(t1),
        .revertive(revertive), .prim_ok(prim_ok), .sec_ok(sec_ok),
        .use_sec(use_sec), .holdover(holdover), .switch_pulse(switch_pulse)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    // Reference generator: each period reads per[] at its rising edge.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (ph[i] == 0) begin
                if (en[i]) begin
                    ref_drv[i] = 1'b1;
                    cur_p[i] = per[i];
                    edges[i] = edges[i] + 1;
                    last_rise[i] = cyc;
                    ph[i] = 1;
                end else begin
                    ref_drv[i] = 1'b0;
                end
            end else begin
                if (ph[i] == cur_p[i] / 2) ref_drv[i] = 1'b0;
                ph[i] = (ph[i] + 1 == cur_p[i]) ? 0 : ph[i] + 1;
            end
        end
    end

    // Monitor: every output transition must match the head of the queue.
    always @(negedge clk) begin
        logic [3:0] now_v;
        logic [3:0] chg;
        if (run_on) begin
            now_v = {holdover, use_sec, sec_ok, prim_ok};
            chg = now_v ^ prev;
            if (chg[3] || chg[2] || switch_pulse)
                check(switch_pulse == (chg[3] | chg[2]), "R9 strobe", int'(switch_pulse),
                      int'(chg[3] | chg[2]));
            for (int k = 0; k < 4; k++) begin
                if (chg[k]) begin
                    if (sbq.size() == 0) begin
                        check(1'b0, "unexpected output change", k, -1);
                    end else begin
                        item_t it;
                        it = sbq.pop_front();
                        check(it.kind == k && it.val == now_v[k], it.req,
                              k * 10 + int'(now_v[k]), it.kind * 10 + int'(it.val));
                        if (it.off >= 0 && k < 2)
                            check(cyc == last_rise[k] + it.off, {it.req, " timing"},
                                  cyc, last_rise[k] + it.off);
                    end
                end
            end
            prev = now_v;
        end
    end

    task automatic expect_ev(input int kind, input bit val, input int off, input string req);
        item_t it;
        it.kind = kind; it.val = val; it.off = off; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
    endtask

    task automatic wait_edges(input int i, input int n);
        int target;
        target = edges[i] + n;
        while (edges[i] < target) @(posedge clk);
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", sbq.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        per[0] = E; per[1] = E;
        en[0] = 0; en[1] = 0;
        ph[0] = 0; ph[1] = 0;
        edges[0] = 0; edges[1] = 0;
        last_rise[0] = 0; last_rise[1] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(prim_ok == 0, "R1 prim_ok", int'(prim_ok), 0);
        check(sec_ok == 0, "R1 sec_ok", int'(sec_ok), 0);
        check(use_sec == 0, "R1 use_sec", int'(use_sec), 0);
        check(holdover == 1, "R1 holdover", int'(holdover), 1);
        check(switch_pulse == 0, "R1 switch_pulse", int'(switch_pulse), 0);
        rst_n = 1'b1;
        prev = {holdover, use_sec, sec_ok, prim_ok};
        run_on = 1'b1;
        @(posedge clk);

        // R5/R7: primary qualifies, holdover ends
        en[0] = 1;
        expect_ev(0, 1, 3, "R5 primary requalify");
        expect_ev(3, 0, -1, "R7 leave holdover");
        drain();
        en[1] = 1;
        expect_ev(1, 1, 3, "R5 secondary requalify");
        drain();

        // R2/R6: primary stops, fall over to secondary
        en[0] = 0;
        expect_ev(0, 0, 2 * E + 3, "R2 primary loss");
        expect_ev(2, 1, -1, "R6 failover to secondary");
        drain();

        // R8: revertive return
        revertive = 1'b1;
        en[0] = 1;
        expect_ev(0, 1, 3, "R5 primary back");
        expect_ev(2, 0, -1, "R8 revert to primary");
        drain();

        // R3: three bad periods then good leaves the flag set
        revertive = 1'b0;
        wait_edges(0, 1);
        per[0] = 26;
        wait_edges(0, 3);
        per[0] = E;
        wait_edges(0, 10);
        check(prim_ok == 1, "R3 three bad periods tolerated", int'(prim_ok), 1);

        // R3/R6: persistent drift drops the primary
        per[0] = 26;
        expect_ev(0, 0, 3, "R3 drift drop");
        expect_ev(2, 1, -1, "R6 failover on drift");
        drain();
        per[0] = E;
        expect_ev(0, 1, 3, "R5 recover after drift");
        drain();
        wait_edges(0, 5);
        check(use_sec == 1, "R8 non-revertive stays", int'(use_sec), 1);

        // R6: secondary lost, back to primary
        en[1] = 0;
        expect_ev(1, 0, 2 * E + 3, "R2 secondary loss");
        expect_ev(2, 0, -1, "R6 failover to primary");
        drain();

        // R7: both lost, holdover
        en[0] = 0;
        expect_ev(0, 0, 2 * E + 3, "R2 primary loss");
        expect_ev(3, 1, -1, "R7 enter holdover");
        drain();
        check(use_sec == 0, "R7 use_sec in holdover", int'(use_sec), 0);

        // R7: secondary alone ends holdover
        en[1] = 1;
        expect_ev(1, 1, 3, "R5 secondary requalify");
        expect_ev(2, 1, -1, "R7 holdover to secondary");
        expect_ev(3, 0, -1, "R7 holdover exit");
        drain();

        // R4: deviation equal to the tolerance is accepted
        per[1] = E + 2;
        wait_edges(1, 12);
        check(sec_ok == 1, "R4 boundary period accepted", int'(sec_ok), 1);
        per[1] = E + 3;
        expect_ev(1, 0, 3, "R3 drift past tolerance");
        expect_ev(2, 0, -1, "R7 to holdover");
        expect_ev(3, 1, -1, "R7 holdover entry");
        drain();

        // R7: both qualify in the same cycle, primary wins
        en[1] = 0;
        repeat (100) @(posedge clk);
        per[0] = E; per[1] = E;
        en[0] = 1; en[1] = 1;
        expect_ev(0, 1, 3, "R5 primary requalify");
        expect_ev(1, 1, 3, "R5 secondary requalify");
        expect_ev(3, 0, -1, "R7 exit holdover");
        drain();
        check(use_sec == 0, "R7 primary preferred", int'(use_sec), 0);
        check(sbq.size() == 0, "scoreboard empty", sbq.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule